// File: doc/BRIEF.md
# Memory-Type-Aware Access Issue Queue

The block sits between a source of explicit loads and stores, which arrive in program order, and a single memory port that carries one transaction at a time. Each incoming request carries a byte address, an access size, a direction, right-justified write data, a memory-type tag and a 4-bit request ID. Requests wait in a compacting queue whose depth is a parameter, and the oldest one is issued first. The memory-type tag controls how each transaction is shaped. Device and strongly-ordered requests leave exactly as they were asked. A normal byte load is widened to an aligned word read. A normal halfword store may absorb a younger normal halfword store that targets the other half of the same word, so the pair leaves as one full-word write. The younger store then moves ahead of everything queued between the two.

A three-state machine drives the port. In IDLE, when the queue holds at least one request, the machine takes the IDLE→ISSUE transition. On that transition it latches the shaped transaction and removes the head from the queue, along with the merge partner if one exists. In ISSUE the request valid is held with stable fields until the memory accepts it, which gives the ISSUE→AWAIT transition. In AWAIT the machine waits for a response-valid and then takes the AWAIT→IDLE transition. For a load, that same response cycle presents the read data to the requester with the original ID. In any state the queue may accept one new request per cycle while it is not full.

Top module: `mem_order_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, in_ready is 1, mem_req_valid is 0 and rd_valid is 0.
- R2: in_ready is 0 exactly when DEPTH requests are waiting in the queue (the request under issue is not counted). A request is taken only in a cycle where both in_valid and in_ready are 1.
- R3: Transactions reach the memory port in program order of their head request. The only exception is the younger store absorbed by a merge (R6).
- R4: A request tagged Device (in_mtype 1) or strongly-ordered (in_mtype 2) is issued once, unmerged, with its own address and size. Its byte enables are: a byte (size 0) sets only lane addr[1:0]; a halfword (size 1) sets 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1; a word (size 2) sets 4'b1111.
- R5: A normal (in_mtype 0) byte load is issued as a word read at the address with bits [1:0] cleared, with size 2 and enables 4'b1111. The requester receives the byte from lane addr[1:0], zero-extended.
- R6: A normal halfword store at the head, aligned (addr[0] = 0), absorbs the oldest queued normal aligned halfword store to the opposite half of the same word. The pair is issued as a single word write: address bits [1:0] are 0, size is 2, enables are 4'b1111, and each half carries the data of its own store. The absorbed store is not issued again.
- R7: No merge happens if a strongly-ordered request or any other request to the same word lies between the two halfword stores. Both stores are then issued separately, in program order.
- R8: When the response to a load arrives (mem_rsp_valid in the AWAIT state), rd_valid is 1 in that same cycle. rd_id is the request ID and rd_data is right-justified and zero-extended: a halfword comes from the upper half when addr[1] is 1. Stores produce no rd_valid.
- R9: At most one transaction is in flight. After a request is accepted, mem_req_valid stays 0 until its response arrives. While mem_req_valid is 1 and mem_req_ready is 0, every request field stays stable.
- R10: Store data on the port sits in the lanes named by the address: a byte is shifted to lane addr[1:0], a halfword goes to the half selected by addr[1], and a word is passed unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New request present |
| in_ready | output | 1 | Queue can take a request |
| in_addr | input | 16 | Byte address |
| in_size | input | 2 | 0 byte, 1 halfword, 2 word |
| in_we | input | 1 | 1 store, 0 load |
| in_wdata | input | 32 | Right-justified store data |
| in_mtype | input | 2 | 0 normal, 1 device, 2 strongly-ordered |
| in_id | input | 4 | Request ID returned with read data |
| mem_req_valid | output | 1 | Transaction offered to memory |
| mem_req_ready | input | 1 | Memory accepts the transaction |
| mem_addr | output | 16 | Issued byte address |
| mem_size | output | 2 | Issued size |
| mem_we | output | 1 | Issued direction |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-positioned write data |
| mem_rsp_valid | input | 1 | Response for the outstanding transaction |
| mem_rsp_rdata | input | 32 | Full-word read data, lane-positioned |
| rd_valid | output | 1 | Load result present |
| rd_id | output | 4 | ID of the returning load |
| rd_data | output | 32 | Right-justified load result |

## Verification
Two events can fall in the same cycle: the IDLE→ISSUE transition removes one or two queue entries (head plus merge partner), and a new request is written into the freed or trailing slot. The bench holds the memory's ready low so that requests pile up. It then releases ready while it is still sending requests, so that merges and enqueues coincide, and it also fills the queue until in_ready drops. A behavioural model queue updated with the same one-cycle alignment predicts in_ready on every clock. It also predicts the exact shape of each issued transaction, and every returned load value against its own memory image.

// File: rtl/moq_pkg.sv
package moq_pkg;
    localparam int MOQ_AW  = 16;
    localparam int MOQ_DW  = 32;
    localparam int MOQ_IDW = 4;
    localparam int MOQ_BEW = MOQ_DW / 8;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'd0,
        MT_DEVICE = 2'd1,
        MT_STRONG = 2'd2
    } mtype_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef struct packed {
        logic [MOQ_AW-1:0] addr;
        size_e             size;
        logic              we;
        mtype_e            mtype;
    } moq_key_t;

    typedef struct packed {
        moq_key_t           key;
        logic [MOQ_DW-1:0]  data;
        logic [MOQ_IDW-1:0] id;
    } moq_ent_t;

    // Pull the requested bytes of a returned word down to bit 0.
    function automatic logic [MOQ_DW-1:0] moq_extract(input logic [MOQ_DW-1:0] w,
                                                      input logic [1:0] lo,
                                                      input size_e sz);
        logic [MOQ_DW-1:0] r;
        case (sz)
            SZ_BYTE: r = {24'h0, w[{lo, 3'b000} +: 8]};
            SZ_HALF: r = {16'h0, (lo[1] ? w[31:16] : w[15:0])};
            default: r = w;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/moq_lane.sv
module moq_lane
    import moq_pkg::*;
(
    input  logic [1:0]         lo,
    input  size_e              size,
    input  logic [MOQ_DW-1:0]  data,
    output logic [MOQ_BEW-1:0] be,
    output logic [MOQ_DW-1:0]  lanes
);
    always_comb begin
        case (size)
            SZ_BYTE: begin
                be    = 4'b0001 << lo;
                lanes = data << {lo, 3'b000};
            end
            SZ_HALF: begin
                be    = lo[1] ? 4'b1100 : 4'b0011;
                lanes = lo[1] ? {data[15:0], 16'h0} : {16'h0, data[15:0]};
            end
            default: begin
                be    = 4'b1111;
                lanes = data;
            end
        endcase
    end
endmodule

// File: rtl/moq_merge_sel.sv
module moq_merge_sel
    import moq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  moq_key_t         keys [DEPTH],
    input  logic [DEPTH-1:0] vld,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic             head_ok;
    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] hazard;

    assign head_ok = vld[0] && keys[0].mtype == MT_NORMAL && keys[0].we &&
                     keys[0].size == SZ_HALF && !keys[0].addr[0];

    assign cand[0]   = 1'b0;
    assign hazard[0] = 1'b0;

    // Per-entry partner match and ordering hazard against the head.
    for (genvar k = 1; k < DEPTH; k++) begin : g_ent
        logic same_word;
        assign same_word = keys[k].addr[MOQ_AW-1:2] == keys[0].addr[MOQ_AW-1:2];
        assign cand[k]   = vld[k] && keys[k].mtype == MT_NORMAL && keys[k].we &&
                           keys[k].size == SZ_HALF && !keys[k].addr[0] && same_word &&
                           (keys[k].addr[1] != keys[0].addr[1]);
        assign hazard[k] = vld[k] && (keys[k].mtype == MT_STRONG || same_word);
    end

    // Oldest partner not fenced off by an earlier hazard.
    always_comb begin
        logic stop;
        stop = 1'b0;
        hit  = 1'b0;
        idx  = '0;
        for (int k = 1; k < DEPTH; k++) begin
            if (!stop) begin
                if (cand[k] && head_ok) begin
                    hit = 1'b1;
                    idx = IDX_W'(k);
                end
                stop = hazard[k];
            end
        end
    end
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
    import moq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [MOQ_AW-1:0]  in_addr,
    input  logic [1:0]         in_size,
    input  logic               in_we,
    input  logic [MOQ_DW-1:0]  in_wdata,
    input  logic [1:0]         in_mtype,
    input  logic [MOQ_IDW-1:0] in_id,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [MOQ_AW-1:0]  mem_addr,
    output logic [1:0]         mem_size,
    output logic               mem_we,
    output logic [MOQ_BEW-1:0] mem_be,
    output logic [MOQ_DW-1:0]  mem_wdata,
    input  logic               mem_rsp_valid,
    input  logic [MOQ_DW-1:0]  mem_rsp_rdata,
    output logic               rd_valid,
    output logic [MOQ_IDW-1:0] rd_id,
    output logic [MOQ_DW-1:0]  rd_data
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_AWAIT} st_e;

    st_e                state, state_n;
    moq_ent_t           q  [DEPTH];
    moq_ent_t           nq [DEPTH];
    moq_key_t           keys [DEPTH];
    logic [DEPTH-1:0]   vld;
    logic [CNT_W-1:0]   count, ncount;
    logic               push, latch;
    moq_ent_t           in_ent;

    logic               mrg_hit;
    logic [IDX_W-1:0]   mrg_idx;
    logic [MOQ_BEW-1:0] hd_be;
    logic [MOQ_DW-1:0]  hd_lanes;
    logic               widen, shape;
    logic [MOQ_AW-1:0]  iss_addr;
    size_e              iss_size;
    logic [MOQ_BEW-1:0] iss_be;
    logic [MOQ_DW-1:0]  iss_wdata;

    logic [MOQ_AW-1:0]  cur_addr;
    size_e              cur_size;
    logic               cur_we;
    logic [MOQ_BEW-1:0] cur_be;
    logic [MOQ_DW-1:0]  cur_wdata;
    logic [MOQ_IDW-1:0] cur_id;
    logic [1:0]         cur_rlo;
    size_e              cur_rsize;

    // ---------------- queue bookkeeping ----------------
    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
        assign vld[i]  = CNT_W'(i) < count;
        assign keys[i] = q[i].key;
    end

    assign in_ready = count < CNT_W'(DEPTH);
    assign push     = in_valid && in_ready;
    assign latch    = (state == ST_IDLE) && vld[0];

    assign in_ent.key.addr  = in_addr;
    assign in_ent.key.size  = size_e'(in_size);
    assign in_ent.key.we    = in_we;
    assign in_ent.key.mtype = mtype_e'(in_mtype);
    assign in_ent.data      = in_wdata;
    assign in_ent.id        = in_id;

    // Remove head (and partner) on latch, compact, append new request.
    always_comb begin
        logic [CNT_W-1:0] w;
        nq = q;
        w  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic drop;
            drop = latch && (i == 0 || (mrg_hit && IDX_W'(i) == mrg_idx));
            if (vld[i] && !drop) begin
                nq[w[IDX_W-1:0]] = q[i];
                w = w + 1'b1;
            end
        end
        if (push) begin
            nq[w[IDX_W-1:0]] = in_ent;
            w = w + 1'b1;
        end
        ncount = w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            count <= ncount;
            q     <= nq;
        end
    end

    // ---------------- transaction shaping ----------------
    moq_merge_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sel (
        .keys (keys),
        .vld  (vld),
        .hit  (mrg_hit),
        .idx  (mrg_idx)
    );

    moq_lane u_lane (
        .lo    (q[0].key.addr[1:0]),
        .size  (q[0].key.size),
        .data  (q[0].data),
        .be    (hd_be),
        .lanes (hd_lanes)
    );

    always_comb begin
        widen    = q[0].key.mtype == MT_NORMAL && !q[0].key.we && q[0].key.size == SZ_BYTE;
        shape    = widen || mrg_hit;
        iss_addr = shape ? {q[0].key.addr[MOQ_AW-1:2], 2'b00} : q[0].key.addr;
        iss_size = shape ? SZ_WORD : q[0].key.size;
        iss_be   = shape ? 4'b1111 : hd_be;
        iss_wdata = hd_lanes;
        if (mrg_hit) begin
            iss_wdata = hd_lanes | (q[mrg_idx].key.addr[1] ? {q[mrg_idx].data[15:0], 16'h0}
                                                           : {16'h0, q[mrg_idx].data[15:0]});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_size  <= SZ_BYTE;
            cur_we    <= 1'b0;
            cur_be    <= '0;
            cur_wdata <= '0;
            cur_id    <= '0;
            cur_rlo   <= '0;
            cur_rsize <= SZ_BYTE;
        end else if (latch) begin
            cur_addr  <= iss_addr;
            cur_size  <= iss_size;
            cur_we    <= q[0].key.we;
            cur_be    <= iss_be;
            cur_wdata <= iss_wdata;
            cur_id    <= q[0].id;
            cur_rlo   <= q[0].key.addr[1:0];
            cur_rsize <= q[0].key.size;
        end
    end

    // ---------------- state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (vld[0])        state_n = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_n = ST_AWAIT;
            ST_AWAIT: if (mem_rsp_valid) state_n = ST_IDLE;
            default:                     state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req_valid = state == ST_ISSUE;
        mem_addr      = cur_addr;
        mem_size      = cur_size;
        mem_we        = cur_we;
        mem_be        = cur_be;
        mem_wdata     = cur_wdata;
        rd_valid      = (state == ST_AWAIT) && mem_rsp_valid && !cur_we;
        rd_id         = cur_id;
        rd_data       = moq_extract(mem_rsp_rdata, cur_rlo, cur_rsize);
    end

    // ---------------- assertions ----------------
    p_depth_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr) &&
        $stable(mem_be) && $stable(mem_wdata) && $stable(mem_we) && $stable(mem_size)));

    p_single_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_rd_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !mem_req_valid);

    p_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && q[0].key.mtype != MT_NORMAL) |=>
        (mem_req_valid && mem_size == $past(q[0].key.size) && mem_be == $past(hd_be)));

    p_be_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                           $countones(mem_be) == 4));

    p_word_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_size == SZ_WORD) |-> (mem_be == 4'b1111 && mem_addr[1:0] == 2'b00));
endmodule

// File: tb/mem_order_queue_tb_top.sv
`timescale 1ns/100ps
module mem_order_queue_tb_top;
    localparam int DEPTH = 4;
    localparam int MN = 0, MD = 1, MS = 2;
    localparam int SB = 0, SH = 1, SW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic [1:0]  in_size = '0;
    logic        in_we = 1'b0;
    logic [31:0] in_wdata = '0;
    logic [1:0]  in_mtype = '0;
    logic [3:0]  in_id = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [15:0] mem_addr;
    logic [1:0]  mem_size;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_id;
    logic [31:0] rd_data;

    always #2.5 clk = ~clk;

    mem_order_queue #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_size(in_size), .in_we(in_we), .in_wdata(in_wdata),
        .in_mtype(in_mtype), .in_id(in_id), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .rd_valid(rd_valid), .rd_id(rd_id), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    typedef struct {
        logic [15:0] a;
        int          sz;
        bit          we;
        logic [31:0] d;
        int          mt;
        logic [3:0]  id;
    } req_t;
    typedef struct {
        logic [3:0]  id;
        logic [31:0] d;
    } rsp_t;

    req_t        mq[$];
    rsp_t        eq[$];
    logic [31:0] mm [16];
    logic [31:0] bmem [16];
    bit          pend = 0;
    req_t        pend_r;
    bit          prev_v = 0, prev_stall = 0, awaiting = 0, full_seen = 0;
    logic [15:0] p_addr; logic [3:0] p_be; logic [31:0] p_wd;
    int          n_merge = 0, n_widen = 0, n_block = 0;
    bit          hold = 1;
    int          cyc = 0;
    logic [3:0]  next_id = 0;

    function automatic logic [3:0] be_of(input logic [1:0] lo, input int sz);
        if (sz == SB) return 4'(1 << lo);
        if (sz == SH) return lo[1] ? 4'hC : 4'h3;
        return 4'hF;
    endfunction

    function automatic logic [31:0] lanes_of(input logic [31:0] d, input logic [1:0] lo, input int sz);
        if (sz == SB) return {24'h0, d[7:0]} << (8 * lo);
        if (sz == SH) return lo[1] ? {d[15:0], 16'h0} : {16'h0, d[15:0]};
        return d;
    endfunction

    function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] lo, input int sz);
        if (sz == SB) return (w >> (8 * lo)) & 32'hFF;
        if (sz == SH) return lo[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
        return w;
    endfunction

    function automatic bit is_hs(input req_t r);
        return r.mt == MN && r.we && r.sz == SH && r.a[0] == 1'b0;
    endfunction

    task automatic model_issue();
        req_t h;
        int pk;
        logic [15:0] ea; int esz; logic [3:0] ebe; logic [31:0] ewd;
        string tag;
        h  = mq[0];
        pk = -1;
        if (is_hs(h)) begin
            for (int k = 1; k < mq.size(); k++) begin
                bit same;
                same = mq[k].a[15:2] == h.a[15:2];
                if (is_hs(mq[k]) && same && mq[k].a[1] != h.a[1]) begin pk = k; break; end
                if (mq[k].mt == MS || same) begin
                    for (int j = k + 1; j < mq.size(); j++)
                        if (is_hs(mq[j]) && mq[j].a[15:2] == h.a[15:2] && mq[j].a[1] != h.a[1]) n_block++;
                    break;
                end
            end
        end
        if (pk >= 0) begin
            ea = {h.a[15:2], 2'b00}; esz = SW; ebe = 4'hF;
            ewd = lanes_of(h.d, h.a[1:0], SH) | lanes_of(mq[pk].d, mq[pk].a[1:0], SH);
            tag = "R6 merged halfword stores"; n_merge++;
        end else if (h.mt == MN && !h.we && h.sz == SB) begin
            ea = {h.a[15:2], 2'b00}; esz = SW; ebe = 4'hF; ewd = 0;
            tag = "R5 widened byte load"; n_widen++;
        end else begin
            ea = h.a; esz = h.sz; ebe = be_of(h.a[1:0], h.sz); ewd = lanes_of(h.d, h.a[1:0], h.sz);
            tag = (h.mt != MN) ? "R4 exact device/strong access" : (h.we ? "R10 store lanes" : "R3 in-order issue");
        end
        check(mem_addr == ea, {tag, " addr"}, 32'(mem_addr), 32'(ea));
        check(mem_size == 2'(esz) && mem_we == h.we, {tag, " size/dir"}, {29'h0, mem_we, mem_size}, {29'h0, h.we, 2'(esz)});
        check(mem_be == ebe, {tag, " enables"}, 32'(mem_be), 32'(ebe));
        if (h.we) begin
            check(mem_wdata == ewd, {tag, " wdata"}, mem_wdata, ewd);
            for (int b = 0; b < 4; b++) if (ebe[b]) mm[ea[5:2]][8*b +: 8] = ewd[8*b +: 8];
        end else begin
            rsp_t r;
            r.id = h.id;
            r.d  = pick(mm[h.a[5:2]], h.a[1:0], h.sz);
            eq.push_back(r);
        end
        if (pk >= 0) mq.delete(pk);
        mq.delete(0);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid && awaiting)
                check(0, "R9 request while outstanding", 1, 0);
            if (prev_stall)
                check(mem_req_valid && mem_addr == p_addr && mem_be == p_be && mem_wdata == p_wd,
                      "R9 stalled request stable", 32'(mem_addr), 32'(p_addr));
            if (mem_req_valid && !prev_v) begin
                if (mq.size() == 0) check(0, "R3 unexpected transaction", 32'(mem_addr), 0);
                else model_issue();
            end
            if (pend) begin mq.push_back(pend_r); pend = 0; end
            check(in_ready == (mq.size() < DEPTH), "R2 in_ready vs occupancy", 32'(in_ready), 32'(mq.size()));
            if (!in_ready) full_seen = 1;
            if (rd_valid) begin
                if (eq.size() == 0) check(0, "R8 unexpected read response", 32'(rd_id), 0);
                else begin
                    check(rd_id == eq[0].id, "R8 response id", 32'(rd_id), 32'(eq[0].id));
                    check(rd_data == eq[0].d, "R8 response data", rd_data, eq[0].d);
                    void'(eq.pop_front());
                end
            end
            if (in_valid && in_ready) begin
                pend = 1;
                pend_r.a = in_addr; pend_r.sz = int'(in_size); pend_r.we = in_we;
                pend_r.d = in_wdata; pend_r.mt = int'(in_mtype); pend_r.id = in_id;
            end
            if (mem_req_valid && mem_req_ready) awaiting = 1;
            if (mem_rsp_valid) awaiting = 0;
            prev_v = mem_req_valid;
            prev_stall = mem_req_valid && !mem_req_ready;
            p_addr = mem_addr; p_be = mem_be; p_wd = mem_wdata;
        end
    end

    // ---------------- memory responder ----------------
    always @(posedge clk) begin
        #1;
        cyc++;
        mem_req_ready = !hold && (cyc % 3 != 0);
    end

    initial begin
        for (int i = 0; i < 16; i++) begin bmem[i] = 0; mm[i] = 0; end
        forever begin
            @(negedge clk);
            if (mem_req_valid && mem_req_ready) begin
                logic [31:0] rv;
                rv = bmem[mem_addr[5:2]];
                if (mem_we)
                    for (int b = 0; b < 4; b++) if (mem_be[b]) bmem[mem_addr[5:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                @(posedge clk); #1;
                mem_rsp_valid = 1; mem_rsp_rdata = rv;
                @(posedge clk); #1;
                mem_rsp_valid = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [15:0] a, input int sz, input bit we, input logic [31:0] d, input int mt);
        in_addr = a; in_size = 2'(sz); in_we = we; in_wdata = d; in_mtype = 2'(mt);
        in_id = next_id; next_id = next_id + 1'b1; in_valid = 1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic drain();
        int n = 0;
        while ((mq.size() != 0 || eq.size() != 0 || pend || mem_req_valid || awaiting) && n < 2000) begin
            @(negedge clk); n++;
        end
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic run_hold(input int cycles);
        repeat (cycles) @(posedge clk);
        #1 hold = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready == 1 && mem_req_valid == 0 && rd_valid == 0, "R1 state in reset",
              {29'h0, in_ready, mem_req_valid, rd_valid}, 32'h4);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        check(in_ready == 1 && mem_req_valid == 0 && rd_valid == 0, "R1 state after reset",
              {29'h0, in_ready, mem_req_valid, rd_valid}, 32'h4);
        @(posedge clk); #1 hold = 0;

        // word init (R3, R10)
        send(16'h0000, SW, 1, 32'h11223344, MN);
        send(16'h0004, SW, 1, 32'h55667788, MN);
        send(16'h0008, SW, 1, 32'h99AABBCC, MN);
        send(16'h000C, SW, 1, 32'hDDEEFF00, MN);
        // exact device / strongly-ordered shapes (R4, R10)
        send(16'h0001, SB, 0, 0, MD);
        send(16'h0006, SH, 0, 0, MD);
        send(16'h0008, SW, 0, 0, MD);
        send(16'h000D, SB, 1, 32'h000000AB, MD);
        send(16'h0002, SH, 1, 32'h0000BEEF, MS);
        send(16'h0003, SB, 0, 0, MS);
        send(16'h000A, SH, 1, 32'h00001234, MS);
        // widened normal byte loads (R5)
        send(16'h0004, SB, 0, 0, MN);
        send(16'h0005, SB, 0, 0, MN);
        send(16'h0006, SB, 0, 0, MN);
        send(16'h0007, SB, 0, 0, MN);
        send(16'h0002, SH, 0, 0, MN);
        send(16'h000C, SW, 0, 0, MN);
        drain();

        // R6 merge, low half first, with an unrelated load between
        hold = 1;
        send(16'h0000, SW, 0, 0, MS);
        send(16'h0010, SH, 1, 32'h00001111, MN);
        send(16'h0014, SW, 0, 0, MN);
        send(16'h0012, SH, 1, 32'h00002222, MN);
        hold = 0;
        drain();
        send(16'h0010, SW, 0, 0, MN);
        drain();

        // R6 merge, high half first, device access between
        hold = 1;
        send(16'h0000, SW, 0, 0, MS);
        send(16'h001A, SH, 1, 32'h0000AAAA, MN);
        send(16'h0004, SH, 0, 0, MD);
        send(16'h0018, SH, 1, 32'h00005555, MN);
        hold = 0;
        drain();
        send(16'h0018, SW, 0, 0, MN);
        drain();

        // R7 blocked by strongly-ordered store
        hold = 1;
        send(16'h0000, SW, 0, 0, MS);
        send(16'h001C, SH, 1, 32'h00003333, MN);
        send(16'h0020, SW, 1, 32'hCAFEF00D, MS);
        send(16'h001E, SH, 1, 32'h00004444, MN);
        hold = 0;
        drain();

        // R7 blocked by same-word load
        hold = 1;
        send(16'h0000, SW, 0, 0, MS);
        send(16'h0024, SH, 1, 32'h00006666, MN);
        send(16'h0026, SH, 0, 0, MN);
        send(16'h0026, SH, 1, 32'h00007777, MN);
        hold = 0;
        drain();
        send(16'h0024, SW, 0, 0, MN);
        drain();

        // R2 fill the queue; R3 mixed-type program order; merge while enqueueing
        hold = 1;
        fork
            begin
                send(16'h0028, SW, 0, 0, MN);
                send(16'h002C, SH, 1, 32'h00000101, MN);
                send(16'h0004, SB, 0, 0, MD);
                send(16'h0008, SB, 0, 0, MD);
                send(16'h002E, SH, 1, 32'h00000202, MN);
                send(16'h0030, SW, 0, 0, MN);
                send(16'h002D, SB, 0, 0, MN);
                send(16'h0034, SW, 1, 32'h0BADBEEF, MN);
                send(16'h0034, SW, 0, 0, MD);
            end
            run_hold(40);
        join
        drain();

        check(full_seen, "R2 queue reached full", 32'(full_seen), 1);
        check(n_merge >= 2, "R6 merges observed", 32'(n_merge), 2);
        check(n_block >= 2, "R7 blocked merges observed", 32'(n_block), 2);
        check(n_widen >= 4, "R5 widened loads observed", 32'(n_widen), 4);
        check(eq.size() == 0 && mq.size() == 0, "R8 all responses delivered", 32'(eq.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule